// File: doc/BRIEF.md
# Multi-Block Transfer Control Counter

This block holds the control settings for one card data transfer and counts its blocks. Software writes a transfer-mode word and the block count values while the block is idle. It then writes the upper byte of the command register, and that write starts the transfer. The data path pulses once for each block it finishes. The counter steps down on each pulse. When the last block is finished, the transfer closes with a one-cycle done pulse. The block also drives the transfer direction and the single or multiple block mode to the data path. When DMA is requested and the system supports it, the block raises a one-cycle DMA start pulse as the transfer begins.

A transfer takes one of three forms. A single-block transfer always moves exactly one block. A counted multi-block transfer moves as many blocks as the loaded count. An unbounded multi-block transfer ignores the count and runs until an external stop request. Two count registers are kept, a short one and a long one. In legacy mode the short count alone sets the length. In version-4 mode a non-zero short count sets the length, and the long count takes over when the short count is zero.

Top module: `blkxfer_ctrl`

## Requirements
- R1: After reset, dir_rd, multi_mode, dma_start, last_blk, xfer_done and xfer_active are all 0.
- R2: A mode write while idle stores mode_wdata. Bit 3 is multi-block (1 = multiple blocks). Bit 2 is direction (1 = card-to-host read, 0 = host-to-card write). Bit 1 is count enable. Bit 0 is DMA request. multi_mode and dir_rd show the new bits from the cycle after the write.
- R3: While xfer_active is 1, writes to the mode word and to both count registers are ignored.
- R4: With bit 3 = 0, a transfer ends after exactly one block-done pulse, whatever the count registers hold. last_blk is 1 from the start of the transfer.
- R5: In a counted multi-block transfer (bit 3 = 1, bit 1 = 1), each block-done pulse lowers the remaining count by one. last_blk is 1 exactly while one block remains. The pulse that finishes the last block drops xfer_active and raises xfer_done for one cycle.
- R6: In an unbounded transfer (bit 3 = 1, bit 1 = 0), block-done pulses never end the transfer and last_blk stays 0. A stop request ends it, with a one-cycle xfer_done.
- R7: With version-4 mode off, the short count sets the length and the long count has no effect.
- R8: With version-4 mode on, a non-zero short count sets the length. When the short count is zero, the long count sets it.
- R9: dma_start is a one-cycle pulse in the cycle after a starting command write. It occurs only when bit 0 is 1 and dma_cap is 1 at that write.
- R10: If a counted multi-block transfer starts with a selected count of zero, xfer_active stays 0 and xfer_done pulses in the next cycle. dma_start does not pulse.
- R11: A command write while a transfer is active is ignored: it does not restart the count and does not pulse dma_start.
- R12: Block-done pulses and stop requests while idle have no effect on the outputs or on the count of the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Transfer-mode write strobe |
| mode_wdata | input | 4 | Mode word: multi, direction, count enable, DMA request |
| cnt_short_wr | input | 1 | Short block count write strobe |
| cnt_short_wdata | input | SHORT_W | Short block count value |
| cnt_long_wr | input | 1 | Long block count write strobe |
| cnt_long_wdata | input | CNT_W | Long block count value |
| cmd_hi_wr | input | 1 | Write to the command register upper byte; starts a transfer |
| blk_pulse | input | 1 | One-cycle pulse from the data path per finished block |
| stop_req | input | 1 | External stop of the running transfer |
| v4_en | input | 1 | Version-4 count selection mode |
| dma_cap | input | 1 | System supports DMA |
| dir_rd | output | 1 | 1 = card-to-host, 0 = host-to-card |
| multi_mode | output | 1 | 1 = multiple-block transfer |
| dma_start | output | 1 | One-cycle DMA start pulse |
| last_blk | output | 1 | Exactly one block remains in a counted transfer |
| xfer_done | output | 1 | One-cycle pulse when a transfer ends |
| xfer_active | output | 1 | A transfer is running |

## Verification
The counting function is tried with single-block, counted and unbounded transfers. This shows that the mode bits decide whether the count is used at all. Short and long count values are loaded under both version modes, including a zero short count. These runs show which register sets the length, and that a zero length finishes at once. Repeated command writes, writes during a transfer, and pulses while idle show that only the first start is accepted and that stray events leave the count untouched.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  localparam int MODE_W  = 4;
  localparam int B_DMA   = 0;
  localparam int B_CNTEN = 1;
  localparam int B_DIR   = 2;
  localparam int B_MULTI = 3;

  typedef struct packed {
    logic multi;
    logic dir_rd;
    logic cnt_en;
    logic dma_en;
  } xfer_mode_t;

  function automatic xfer_mode_t unpack_mode(input logic [MODE_W-1:0] w);
    xfer_mode_t m;
    m.multi  = w[B_MULTI];
    m.dir_rd = w[B_DIR];
    m.cnt_en = w[B_CNTEN];
    m.dma_en = w[B_DMA];
    return m;
  endfunction

  function automatic logic is_unbounded(input xfer_mode_t m);
    return m.multi & ~m.cnt_en;
  endfunction
endpackage

// File: rtl/xfer_mode_reg.sv
module xfer_mode_reg
  import blkxfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  input  logic              lock,
  output xfer_mode_t        mode
);
  xfer_mode_t mode_q;
  logic       wr_take;

  assign wr_take = wr & ~lock;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_take) mode_q <= unpack_mode(wdata);
  end

  assign mode = mode_q;

  p_mode_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mode_q));
endmodule

// File: rtl/xfer_count_sel.sv
module xfer_count_sel #(
  parameter int SHORT_W = 16,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               short_wr,
  input  logic [SHORT_W-1:0] short_wdata,
  input  logic               long_wr,
  input  logic [CNT_W-1:0]   long_wdata,
  input  logic               lock,
  input  logic               v4_en,
  output logic [CNT_W-1:0]   load_val
);
  localparam int PAD_W = CNT_W - SHORT_W;

  logic [SHORT_W-1:0] short_q;
  logic [CNT_W-1:0]   long_q;

  function automatic logic [CNT_W-1:0] pick_count(
    input logic v4, input logic [SHORT_W-1:0] s, input logic [CNT_W-1:0] l);
    logic [CNT_W-1:0] s_ext;
    s_ext = {{PAD_W{1'b0}}, s};
    if (!v4) return s_ext;
    return (s != '0) ? s_ext : l;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      short_q <= '0;
      long_q  <= '0;
    end else if (!lock) begin
      if (short_wr) short_q <= short_wdata;
      if (long_wr)  long_q  <= long_wdata;
    end
  end

  assign load_val = pick_count(v4_en, short_q, long_q);

  p_cnt_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(short_q) && $stable(long_q)));
  p_legacy_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !v4_en |-> (load_val[CNT_W-1:SHORT_W] == '0));
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import blkxfer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             blk_pulse,
  input  logic             stop_req,
  input  logic             dma_cap,
  input  xfer_mode_t       mode,
  input  logic [CNT_W-1:0] load_val,
  output logic             active,
  output logic             last_blk,
  output logic             done,
  output logic             dma_start
);
  logic             active_q, inf_q, done_q, dma_q;
  logic [CNT_W-1:0] remain_q;
  logic             start_ok, zero_start, blk_step, ends_now;
  logic [CNT_W-1:0] eff_count;

  function automatic logic [CNT_W-1:0] first_count(
    input xfer_mode_t m, input logic [CNT_W-1:0] lv);
    return m.multi ? lv : CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  assign start_ok   = start_req & ~active_q;
  assign eff_count  = first_count(mode, load_val);
  assign zero_start = start_ok & ~is_unbounded(mode) & (eff_count == '0);
  assign blk_step   = active_q & ~inf_q & blk_pulse & ~stop_req;
  assign ends_now   = blk_step & (remain_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      inf_q    <= 1'b0;
      done_q   <= 1'b0;
      dma_q    <= 1'b0;
      remain_q <= '0;
    end else begin
      done_q <= 1'b0;
      dma_q  <= 1'b0;
      if (start_ok) begin
        if (zero_start) begin
          done_q <= 1'b1;
        end else begin
          active_q <= 1'b1;
          inf_q    <= is_unbounded(mode);
          remain_q <= eff_count;
          dma_q    <= mode.dma_en & dma_cap;
        end
      end else if (active_q) begin
        if (stop_req) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          remain_q <= '0;
        end else if (blk_step) begin
          remain_q <= step_down(remain_q);
          if (ends_now) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign active    = active_q;
  assign last_blk  = active_q & ~inf_q & (remain_q == CNT_W'(1));
  assign done      = done_q;
  assign dma_start = dma_q;

  p_dma_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |=> !dma_q);
  p_dma_needs_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> !dma_q);
  p_done_on_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> done_q);
  p_last_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_blk && blk_pulse) |=> (done_q && !active_q));
  p_inf_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && inf_q && !stop_req) |=> active_q);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start_req) |=> (!done_q && !active_q));
endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic [MODE_W-1:0]  mode_wdata,
  input  logic               cnt_short_wr,
  input  logic [SHORT_W-1:0] cnt_short_wdata,
  input  logic               cnt_long_wr,
  input  logic [CNT_W-1:0]   cnt_long_wdata,
  input  logic               cmd_hi_wr,
  input  logic               blk_pulse,
  input  logic               stop_req,
  input  logic               v4_en,
  input  logic               dma_cap,
  output logic               dir_rd,
  output logic               multi_mode,
  output logic               dma_start,
  output logic               last_blk,
  output logic               xfer_done,
  output logic               xfer_active
);
  xfer_mode_t       mode;
  logic             busy;
  logic [CNT_W-1:0] load_val;

  xfer_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (mode_wr),
    .wdata (mode_wdata),
    .lock  (busy),
    .mode  (mode)
  );

  xfer_count_sel #(.SHORT_W(SHORT_W), .CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .short_wr    (cnt_short_wr),
    .short_wdata (cnt_short_wdata),
    .long_wr     (cnt_long_wr),
    .long_wdata  (cnt_long_wdata),
    .lock        (busy),
    .v4_en       (v4_en),
    .load_val    (load_val)
  );

  xfer_engine #(.CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (cmd_hi_wr),
    .blk_pulse (blk_pulse),
    .stop_req  (stop_req),
    .dma_cap   (dma_cap),
    .mode      (mode),
    .load_val  (load_val),
    .active    (busy),
    .last_blk  (last_blk),
    .done      (xfer_done),
    .dma_start (dma_start)
  );

  assign dir_rd      = mode.dir_rd;
  assign multi_mode  = mode.multi;
  assign xfer_active = busy;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!xfer_active && !dma_start && !xfer_done));
  p_start_only_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && cmd_hi_wr) |=> !dma_start);
endmodule

// File: tb/sim_blkxfer_ctrl.sv
module sim_blkxfer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [3:0]  mode_wdata = '0;
  logic        cnt_short_wr = 1'b0;
  logic [15:0] cnt_short_wdata = '0;
  logic        cnt_long_wr = 1'b0;
  logic [31:0] cnt_long_wdata = '0;
  logic        cmd_hi_wr = 1'b0;
  logic        blk_pulse = 1'b0;
  logic        stop_req = 1'b0;
  logic        v4_en = 1'b0;
  logic        dma_cap = 1'b0;
  logic        dir_rd, multi_mode, dma_start, last_blk, xfer_done, xfer_active;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  blkxfer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .cnt_short_wr(cnt_short_wr), .cnt_short_wdata(cnt_short_wdata),
    .cnt_long_wr(cnt_long_wr), .cnt_long_wdata(cnt_long_wdata),
    .cmd_hi_wr(cmd_hi_wr), .blk_pulse(blk_pulse), .stop_req(stop_req),
    .v4_en(v4_en), .dma_cap(dma_cap), .dir_rd(dir_rd), .multi_mode(multi_mode),
    .dma_start(dma_start), .last_blk(last_blk), .xfer_done(xfer_done),
    .xfer_active(xfer_active)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // mode word: [3]=multi [2]=dir read [1]=count enable [0]=dma request
  task automatic set_mode(input logic m, input logic d, input logic c, input logic dm);
    mode_wr = 1'b1; mode_wdata = {m, d, c, dm};
    step();
    mode_wr = 1'b0;
  endtask

  task automatic set_counts(input logic [15:0] s, input logic [31:0] l);
    cnt_short_wr = 1'b1; cnt_short_wdata = s;
    cnt_long_wr = 1'b1;  cnt_long_wdata = l;
    step();
    cnt_short_wr = 1'b0; cnt_long_wr = 1'b0;
  endtask

  task automatic cmd();
    cmd_hi_wr = 1'b1; step(); cmd_hi_wr = 1'b0;
  endtask

  task automatic blk();
    blk_pulse = 1'b1; step(); blk_pulse = 1'b0;
  endtask

  task automatic stop();
    stop_req = 1'b1; step(); stop_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 dir_rd", dir_rd, 0);
    chk("R1 multi_mode", multi_mode, 0);
    chk("R1 dma_start", dma_start, 0);
    chk("R1 last_blk", last_blk, 0);
    chk("R1 xfer_done", xfer_done, 0);
    chk("R1 xfer_active", xfer_active, 0);
  endtask

  task automatic t_mode();
    set_mode(1, 1, 0, 0);
    chk("R2 multi set", multi_mode, 1);
    chk("R2 dir read", dir_rd, 1);
    set_mode(0, 0, 1, 0);
    chk("R2 multi clear", multi_mode, 0);
    chk("R2 dir write", dir_rd, 0);
  endtask

  task automatic t_single();
    v4_en = 1'b0;
    set_counts(16'd5, 32'd9);
    set_mode(0, 0, 1, 0);
    cmd();
    chk("R4 active", xfer_active, 1);
    chk("R4 last at start", last_blk, 1);
    blk();
    chk("R4 done after one", xfer_done, 1);
    chk("R4 inactive", xfer_active, 0);
    step();
    chk("R4 done one cycle", xfer_done, 0);
  endtask

  task automatic t_multi_and_lock();
    set_counts(16'd3, 32'd0);
    set_mode(1, 1, 1, 0);
    cmd();
    chk("R5 active", xfer_active, 1);
    chk("R5 last at 3", last_blk, 0);
    set_mode(0, 0, 1, 0);
    chk("R3 multi kept", multi_mode, 1);
    chk("R3 dir kept", dir_rd, 1);
    set_counts(16'd1, 32'd0);
    blk();
    chk("R5 last at 2", last_blk, 0);
    blk();
    chk("R5 last at 1", last_blk, 1);
    chk("R5 done early", xfer_done, 0);
    blk();
    chk("R5 done", xfer_done, 1);
    chk("R5 inactive", xfer_active, 0);
    step();
    chk("R5 done pulse ends", xfer_done, 0);
    // count write during transfer was ignored: short count is still 3
    cmd();
    blk();
    chk("R3 count kept", last_blk, 0);
    stop();
    chk("R3 stopped", xfer_active, 0);
  endtask

  task automatic t_unbounded();
    set_mode(1, 0, 0, 0);
    cmd();
    for (int i = 0; i < 5; i++) blk();
    chk("R6 still active", xfer_active, 1);
    chk("R6 no last", last_blk, 0);
    chk("R6 no done", xfer_done, 0);
    stop();
    chk("R6 done on stop", xfer_done, 1);
    chk("R6 inactive", xfer_active, 0);
  endtask

  task automatic t_legacy_zero();
    v4_en = 1'b0; dma_cap = 1'b1;
    set_counts(16'd0, 32'd2);
    set_mode(1, 0, 1, 1);
    cmd();
    chk("R7 long ignored", xfer_active, 0);
    chk("R10 zero done", xfer_done, 1);
    chk("R10 no dma", dma_start, 0);
    step();
    chk("R10 done one cycle", xfer_done, 0);
  endtask

  task automatic t_v4();
    v4_en = 1'b1; dma_cap = 1'b0;
    set_counts(16'd0, 32'd2);
    set_mode(1, 0, 1, 0);
    cmd();
    chk("R8 long used", last_blk, 0);
    blk();
    chk("R8 long last", last_blk, 1);
    blk();
    chk("R8 long done", xfer_done, 1);
    set_counts(16'd1, 32'd4);
    cmd();
    chk("R8 short wins", last_blk, 1);
    blk();
    chk("R8 short done", xfer_done, 1);
    v4_en = 1'b0;
  endtask

  task automatic t_dma();
    dma_cap = 1'b1;
    set_mode(0, 1, 1, 1);
    cmd();
    chk("R9 dma pulse", dma_start, 1);
    step();
    chk("R9 dma one cycle", dma_start, 0);
    blk();
    dma_cap = 1'b0;
    cmd();
    chk("R9 no dma without cap", dma_start, 0);
    blk();
    chk("R9 ended", xfer_active, 0);
  endtask

  task automatic t_restart();
    dma_cap = 1'b1;
    set_counts(16'd3, 32'd0);
    set_mode(1, 0, 1, 1);
    cmd();
    step();
    blk();
    cmd();
    chk("R11 no second dma", dma_start, 0);
    blk();
    chk("R11 count not reloaded", last_blk, 1);
    blk();
    chk("R11 done", xfer_done, 1);
    dma_cap = 1'b0;
  endtask

  task automatic t_idle();
    set_counts(16'd2, 32'd0);
    set_mode(1, 0, 1, 0);
    blk(); blk(); stop();
    chk("R12 idle no done", xfer_done, 0);
    chk("R12 idle inactive", xfer_active, 0);
    cmd();
    blk();
    chk("R12 count intact", last_blk, 1);
    blk();
    chk("R12 done", xfer_done, 1);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_mode();
    t_single();
    t_multi_and_lock();
    t_unbounded();
    t_legacy_zero();
    t_v4();
    t_dma();
    t_restart();
    t_idle();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule